// File: doc/BRIEF.md
# Bridge Downstream Lock Controller

This block governs exclusive-access sequences that cross a two-port bridge from the primary bus to the secondary bus. It watches requests that the primary-side decoder has already classified, and answers each one in the same cycle. The answer is one of three: accept and queue it, answer with a target retry, or return the delayed read data. Locked requests that arrive from the secondary side are always answered with a retry and never go further.

A locked sequence must open with a memory read. The block queues that read as a locked, non-prefetchable delayed request. It then waits until every older queued transaction has drained. Next it waits for the secondary bus to be idle with no lock held by another initiator, and only then requests the bus. It issues the read with the lock pin high during the address phase and low from the following clock on. Once a data transfer completes, the secondary side counts as locked. The primary side counts as locked when the initiator repeats the read as a locked access with the same address and byte enables.

While the locked read is pending, every other request aimed across the bridge is retried. After both sides are locked, further locked reads and writes are forwarded as locked transactions. Writes are posted and reads are not prefetched. The lock ends when the primary bus is seen idle, with both the frame and lock pins high. If the discard timer expires while the read is pending, the queued read and its data are dropped, the secondary lock pin is released, and a one-cycle system-error pulse is raised if that report is enabled.

Top module: `bridge_lock_ctrl`

## Requirements
- R1: After reset, neither lock flag (`lock_sec_est`, `lock_pri_est`) is set, `s_lock_oe` and `s_req` are low, `serr_n` is high, and no response strobe is active.
- R2: With no lock present, a primary request with `p_req_locked` low is accepted and queued in the same cycle. Command 2'b01 (memory write) is marked posted. Command 2'b00 (memory read) is marked prefetchable. Any other command is neither posted nor prefetchable.
- R3: A locked request on the secondary side (`s_up_lock_req`) is answered with `s_up_lock_retry` in the same cycle and never enqueued.
- R4: With no lock present, a locked request is accepted only if its command is 2'b00 and `s_lock_n_in` is high. Otherwise it is retried and nothing changes. An accepted one is enqueued locked, not posted and not prefetchable.
- R5: From the acceptance of the opening locked read until the primary lock is established, every primary request is retried and nothing is enqueued. The only exception is the matching repeat described in R8.
- R6: `s_req` rises only after the older queue has drained (`q_older_empty`), and only while `s_lock_n_in` and `s_bus_idle` are both high.
- R7: On `s_gnt`, the next cycle is an address phase with `s_lock_oe` high and `s_lock_n_out` high. From the following cycle, `s_lock_n_out` stays low for as long as the lock is held.
- R8: `lock_sec_est` sets the cycle after `s_data_xfer`. After that, a locked memory-read repeat whose address and byte enables equal those of the opening read gets `p_data_ret`, and `lock_pri_est` sets on the next cycle. Any other repeat is retried.
- R9: `master_timeout` while the read is pending raises `q_discard` in the same cycle. On the next cycle the lock flags and `s_lock_oe` are clear. `serr_n` is low for exactly that one cycle when `serr_en` is high, and stays high otherwise.
- R10: With both sides locked, locked reads and writes are accepted and enqueued locked. Writes are posted and nothing is prefetchable. Unlocked requests and other commands are retried.
- R11: With both sides locked, the lock is released only on a cycle where `p_frame_n` and `p_lock_n` are both high. On the next cycle both flags and `s_lock_oe` are clear, and unlocked traffic is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p_req_valid | input | 1 | Decoded primary request aimed at the secondary side |
| p_req_locked | input | 1 | Request used the high-then-low lock pin sequence |
| p_req_cmd | input | 2 | 00 memory read, 01 memory write, others non-memory |
| p_addr | input | ADDR_W | Request address |
| p_be | input | BE_W | Request byte enables |
| p_frame_n | input | 1 | Primary frame pin as sampled |
| p_lock_n | input | 1 | Primary lock pin as sampled |
| p_accept | output | 1 | Request accepted |
| p_retry | output | 1 | Request answered with target retry |
| p_data_ret | output | 1 | Locked read data returned to the initiator |
| q_enq | output | 1 | Enqueue strobe |
| q_enq_locked | output | 1 | Enqueued entry must be driven locked |
| q_post | output | 1 | Enqueued entry is a posted write |
| q_prefetch | output | 1 | Enqueued read may prefetch |
| q_older_empty | input | 1 | All entries older than the locked read are done |
| q_discard | output | 1 | Drop the queued locked read and its data |
| s_up_lock_req | input | 1 | Locked request seen on the secondary side |
| s_up_lock_retry | output | 1 | Retry answer for that request |
| s_lock_n_in | input | 1 | Secondary lock pin as sampled |
| s_bus_idle | input | 1 | Secondary bus idle |
| s_gnt | input | 1 | Secondary bus grant |
| s_data_xfer | input | 1 | Data transfer of the locked read completed |
| s_req | output | 1 | Secondary bus request |
| s_addr_phase | output | 1 | Address phase of the locked read |
| s_lock_oe | output | 1 | Drive enable of the secondary lock pin |
| s_lock_n_out | output | 1 | Value driven on the secondary lock pin |
| master_timeout | input | 1 | Discard timer expired |
| serr_en | input | 1 | System-error report enable |
| serr_n | output | 1 | Registered system-error pulse, active low |
| lock_sec_est | output | 1 | Secondary side locked |
| lock_pri_est | output | 1 | Primary side locked |

## Verification
The bench builds the block with a 3-bit address and 2-bit byte enables. At that size, every address and byte-enable pair can be tried against the captured values, each both with and without the lock sequence, while the locked read waits for its repeat. That makes the five-bit match compare fully exercised. Every command is swept both locked and unlocked in the idle, pending and locked states. The bus-request gating is walked through each of its three qualifiers, and the discard path is run with the error report enabled and then disabled.

// File: rtl/lkc_pkg.sv
// Shared types for the downstream lock controller.
// Assumes a two-bit command code decoded upstream of this block.
package lkc_pkg;

    localparam logic [1:0] CMD_MRD = 2'b00;
    localparam logic [1:0] CMD_MWR = 2'b01;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_DRAIN,
        LK_WAITBUS,
        LK_ADDR,
        LK_HOLD,
        LK_SEC,
        LK_BOTH
    } lk_state_e;

    // True for every state between acceptance and primary-side lock.
    function automatic logic lk_pending(input lk_state_e s);
        return (s == LK_DRAIN) || (s == LK_WAITBUS) || (s == LK_ADDR) ||
               (s == LK_HOLD)  || (s == LK_SEC);
    endfunction

    // True while the secondary lock pin is being driven by this block.
    function automatic logic lk_drives_pin(input lk_state_e s);
        return (s == LK_ADDR) || (s == LK_HOLD) || (s == LK_SEC) || (s == LK_BOTH);
    endfunction

endpackage

// File: rtl/lkc_admit.sv
// Admission decision for primary-side requests.
// Purely combinational: answers accept, retry or data-return in the cycle
// the decoder presents the request, and derives the queue attributes.
// Assumes the captured tag holds {address, byte enables} of the opening read.
module lkc_admit
    import lkc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4,
    localparam int TAG_W = ADDR_W + BE_W
) (
    input  lk_state_e         state,
    input  logic              req_valid,
    input  logic              req_locked,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [TAG_W-1:0]  cap_tag,
    input  logic              sec_bus_locked,
    output logic              accept,
    output logic              retry,
    output logic              data_ret,
    output logic              enq,
    output logic              enq_locked,
    output logic              post,
    output logic              prefetch,
    output logic              lock_start
);

    logic is_rd;
    logic is_wr;
    logic tag_hit;

    // Command and repeat-match decode.
    always_comb begin
        is_rd   = (req_cmd == CMD_MRD);
        is_wr   = (req_cmd == CMD_MWR);
        tag_hit = ({req_addr, req_be} == cap_tag);
    end

    // Per-state response selection.
    always_comb begin
        accept     = 1'b0;
        retry      = 1'b0;
        data_ret   = 1'b0;
        enq        = 1'b0;
        enq_locked = 1'b0;
        post       = 1'b0;
        prefetch   = 1'b0;
        lock_start = 1'b0;
        if (req_valid) begin
            case (state)
                LK_IDLE: begin
                    if (!req_locked) begin
                        accept   = 1'b1;
                        enq      = 1'b1;
                        post     = is_wr;
                        prefetch = is_rd;
                    end else if (is_rd && !sec_bus_locked) begin
                        accept     = 1'b1;
                        enq        = 1'b1;
                        enq_locked = 1'b1;
                        lock_start = 1'b1;
                    end else begin
                        retry = 1'b1;
                    end
                end
                LK_SEC: begin
                    if (req_locked && is_rd && tag_hit) data_ret = 1'b1;
                    else                                retry    = 1'b1;
                end
                LK_BOTH: begin
                    if (req_locked && (is_rd || is_wr)) begin
                        accept     = 1'b1;
                        enq        = 1'b1;
                        enq_locked = 1'b1;
                        post       = is_wr;
                    end else begin
                        retry = 1'b1;
                    end
                end
                default: retry = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/lkc_fsm.sv
// Lock sequence state machine.
// Tracks the locked read from acceptance through drain, bus wait, address
// phase, secondary lock, primary lock and release; captures the repeat tag.
// Assumes single-cycle strobes for grant, data transfer and timeout.
module lkc_fsm
    import lkc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4,
    localparam int TAG_W = ADDR_W + BE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_start,
    input  logic              data_ret,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic              older_empty,
    input  logic              bus_req,
    input  logic              bus_gnt,
    input  logic              data_xfer,
    input  logic              master_timeout,
    input  logic              p_frame_n,
    input  logic              p_lock_n,
    output lk_state_e         state,
    output logic [TAG_W-1:0]  cap_tag,
    output logic              abort
);

    lk_state_e nxt;

    // Timeout only matters while the locked read is outstanding.
    always_comb abort = lk_pending(state) && master_timeout;

    // Next-state selection.
    always_comb begin
        nxt = state;
        if (abort) begin
            nxt = LK_IDLE;
        end else begin
            case (state)
                LK_IDLE:    if (lock_start)          nxt = LK_DRAIN;
                LK_DRAIN:   if (older_empty)         nxt = LK_WAITBUS;
                LK_WAITBUS: if (bus_req && bus_gnt)  nxt = LK_ADDR;
                LK_ADDR:                             nxt = LK_HOLD;
                LK_HOLD:    if (data_xfer)           nxt = LK_SEC;
                LK_SEC:     if (data_ret)            nxt = LK_BOTH;
                LK_BOTH:    if (p_frame_n && p_lock_n) nxt = LK_IDLE;
                default:                             nxt = LK_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LK_IDLE;
        else        state <= nxt;
    end

    // Capture address and byte enables of the opening locked read.
    always_ff @(posedge clk) begin
        if (!rst_n)          cap_tag <= '0;
        else if (lock_start) cap_tag <= {req_addr, req_be};
    end

endmodule

// File: rtl/lkc_sec_drv.sv
// Secondary-side pin control and status outputs.
// Requests the secondary bus only when it is idle and unlocked, drives the
// lock pin high in the address phase and low afterwards, and registers the
// system-error pulse on a discard.
// Assumes the bus interface gates s_lock_n_out with s_lock_oe.
module lkc_sec_drv
    import lkc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lk_state_e state,
    input  logic      s_lock_n_in,
    input  logic      s_bus_idle,
    input  logic      abort,
    input  logic      serr_en,
    output logic      s_req,
    output logic      s_addr_phase,
    output logic      s_lock_oe,
    output logic      s_lock_n_out,
    output logic      sec_est,
    output logic      pri_est,
    output logic      serr_n
);

    // Pin and flag decode from the sequence state.
    always_comb begin
        s_req        = (state == LK_WAITBUS) && s_lock_n_in && s_bus_idle;
        s_addr_phase = (state == LK_ADDR);
        s_lock_oe    = lk_drives_pin(state);
        s_lock_n_out = !(lk_drives_pin(state) && (state != LK_ADDR));
        sec_est      = (state == LK_SEC) || (state == LK_BOTH);
        pri_est      = (state == LK_BOTH);
    end

    // One-cycle system-error report following a discard.
    always_ff @(posedge clk) begin
        if (!rst_n) serr_n <= 1'b1;
        else        serr_n <= !(abort && serr_en);
    end

endmodule

// File: rtl/bridge_lock_ctrl.sv
// Downstream lock controller for a two-port bridge.
// Ties admission, the sequence state machine and the secondary pin driver
// together. Assumes requests are decoded one per cycle by the primary target.
module bridge_lock_ctrl
    import lkc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p_req_valid,
    input  logic              p_req_locked,
    input  logic [1:0]        p_req_cmd,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [BE_W-1:0]   p_be,
    input  logic              p_frame_n,
    input  logic              p_lock_n,
    output logic              p_accept,
    output logic              p_retry,
    output logic              p_data_ret,
    output logic              q_enq,
    output logic              q_enq_locked,
    output logic              q_post,
    output logic              q_prefetch,
    input  logic              q_older_empty,
    output logic              q_discard,
    input  logic              s_up_lock_req,
    output logic              s_up_lock_retry,
    input  logic              s_lock_n_in,
    input  logic              s_bus_idle,
    input  logic              s_gnt,
    input  logic              s_data_xfer,
    output logic              s_req,
    output logic              s_addr_phase,
    output logic              s_lock_oe,
    output logic              s_lock_n_out,
    input  logic              master_timeout,
    input  logic              serr_en,
    output logic              serr_n,
    output logic              lock_sec_est,
    output logic              lock_pri_est
);

    localparam int TAG_W = ADDR_W + BE_W;

    lk_state_e        state;
    logic [TAG_W-1:0] cap_tag;
    logic             lock_start;
    logic             abort;

    // Upstream locked requests are never forwarded.
    always_comb s_up_lock_retry = s_up_lock_req;

    // Discard the queued read whenever the sequence aborts.
    always_comb q_discard = abort;

    lkc_admit #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_admit (
        .state          (state),
        .req_valid      (p_req_valid),
        .req_locked     (p_req_locked),
        .req_cmd        (p_req_cmd),
        .req_addr       (p_addr),
        .req_be         (p_be),
        .cap_tag        (cap_tag),
        .sec_bus_locked (!s_lock_n_in),
        .accept         (p_accept),
        .retry          (p_retry),
        .data_ret       (p_data_ret),
        .enq            (q_enq),
        .enq_locked     (q_enq_locked),
        .post           (q_post),
        .prefetch       (q_prefetch),
        .lock_start     (lock_start)
    );

    lkc_fsm #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .lock_start     (lock_start),
        .data_ret       (p_data_ret),
        .req_addr       (p_addr),
        .req_be         (p_be),
        .older_empty    (q_older_empty),
        .bus_req        (s_req),
        .bus_gnt        (s_gnt),
        .data_xfer      (s_data_xfer),
        .master_timeout (master_timeout),
        .p_frame_n      (p_frame_n),
        .p_lock_n       (p_lock_n),
        .state          (state),
        .cap_tag        (cap_tag),
        .abort          (abort)
    );

    lkc_sec_drv u_sec (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .s_lock_n_in  (s_lock_n_in),
        .s_bus_idle   (s_bus_idle),
        .abort        (abort),
        .serr_en      (serr_en),
        .s_req        (s_req),
        .s_addr_phase (s_addr_phase),
        .s_lock_oe    (s_lock_oe),
        .s_lock_n_out (s_lock_n_out),
        .sec_est      (lock_sec_est),
        .pri_est      (lock_pri_est),
        .serr_n       (serr_n)
    );

endmodule

// File: rtl/lkc_chk.sv
// Temporal checks on the lock controller's ports, bound to the top module.
module lkc_chk (
    input logic clk,
    input logic rst_n,
    input logic p_accept,
    input logic p_retry,
    input logic p_data_ret,
    input logic q_enq,
    input logic q_enq_locked,
    input logic q_prefetch,
    input logic q_discard,
    input logic s_up_lock_req,
    input logic s_up_lock_retry,
    input logic s_lock_n_in,
    input logic s_bus_idle,
    input logic s_req,
    input logic s_addr_phase,
    input logic s_lock_oe,
    input logic s_lock_n_out,
    input logic serr_en,
    input logic serr_n,
    input logic lock_sec_est,
    input logic lock_pri_est
);

    // R2
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({p_accept, p_retry, p_data_ret}));

    // R3
    up_lock_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_up_lock_req |-> s_up_lock_retry);

    // R4
    lock_rd_noprefetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_enq_locked |-> !q_prefetch);

    // R5
    pending_no_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_lock_oe && !lock_pri_est) |-> !q_enq);

    // R6
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_req |-> (s_lock_n_in && s_bus_idle));

    // R7
    addr_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_addr_phase |=> (s_lock_oe && !s_lock_n_out));

    // R8
    pri_needs_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_pri_est |-> lock_sec_est);

    // R8
    data_ret_sets_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_data_ret |=> lock_pri_est);

    // R9
    discard_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_discard |=> (!s_lock_oe && !lock_sec_est));

    // R9
    serr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(q_discard && serr_en));

endmodule

bind bridge_lock_ctrl lkc_chk u_lkc_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .p_accept        (p_accept),
    .p_retry         (p_retry),
    .p_data_ret      (p_data_ret),
    .q_enq           (q_enq),
    .q_enq_locked    (q_enq_locked),
    .q_prefetch      (q_prefetch),
    .q_discard       (q_discard),
    .s_up_lock_req   (s_up_lock_req),
    .s_up_lock_retry (s_up_lock_retry),
    .s_lock_n_in     (s_lock_n_in),
    .s_bus_idle      (s_bus_idle),
    .s_req           (s_req),
    .s_addr_phase    (s_addr_phase),
    .s_lock_oe       (s_lock_oe),
    .s_lock_n_out    (s_lock_n_out),
    .serr_en         (serr_en),
    .serr_n          (serr_n),
    .lock_sec_est    (lock_sec_est),
    .lock_pri_est    (lock_pri_est)
);

// File: tb/bridge_lock_ctrl_test.sv
module bridge_lock_ctrl_test;

    localparam int AW = 3;
    localparam int BW = 2;
    localparam logic [AW-1:0] LA = 3'd5;
    localparam logic [BW-1:0] LB = 2'd2;

    logic clk = 1'b0;
    logic rst_n;
    logic p_req_valid, p_req_locked;
    logic [1:0] p_req_cmd;
    logic [AW-1:0] p_addr;
    logic [BW-1:0] p_be;
    logic p_frame_n, p_lock_n;
    logic p_accept, p_retry, p_data_ret;
    logic q_enq, q_enq_locked, q_post, q_prefetch, q_older_empty, q_discard;
    logic s_up_lock_req, s_up_lock_retry;
    logic s_lock_n_in, s_bus_idle, s_gnt, s_data_xfer;
    logic s_req, s_addr_phase, s_lock_oe, s_lock_n_out;
    logic master_timeout, serr_en, serr_n, lock_sec_est, lock_pri_est;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bridge_lock_ctrl #(.ADDR_W(AW), .BE_W(BW)) uut (
        .clk(clk), .rst_n(rst_n),
        .p_req_valid(p_req_valid), .p_req_locked(p_req_locked), .p_req_cmd(p_req_cmd),
        .p_addr(p_addr), .p_be(p_be), .p_frame_n(p_frame_n), .p_lock_n(p_lock_n),
        .p_accept(p_accept), .p_retry(p_retry), .p_data_ret(p_data_ret),
        .q_enq(q_enq), .q_enq_locked(q_enq_locked), .q_post(q_post), .q_prefetch(q_prefetch),
        .q_older_empty(q_older_empty), .q_discard(q_discard),
        .s_up_lock_req(s_up_lock_req), .s_up_lock_retry(s_up_lock_retry),
        .s_lock_n_in(s_lock_n_in), .s_bus_idle(s_bus_idle), .s_gnt(s_gnt),
        .s_data_xfer(s_data_xfer), .s_req(s_req), .s_addr_phase(s_addr_phase),
        .s_lock_oe(s_lock_oe), .s_lock_n_out(s_lock_n_out),
        .master_timeout(master_timeout), .serr_en(serr_en), .serr_n(serr_n),
        .lock_sec_est(lock_sec_est), .lock_pri_est(lock_pri_est)
    );

    task automatic chk(input string rq, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %b expected %b", rq, got, exp);
        end
    endtask

    // Advance one edge and settle away from it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic lk, input logic [1:0] c,
                         input logic [AW-1:0] a, input logic [BW-1:0] b);
        p_req_valid = 1'b1; p_req_locked = lk; p_req_cmd = c; p_addr = a; p_be = b;
        #2;
    endtask

    task automatic idle_req();
        p_req_valid = 1'b0; p_req_locked = 1'b0;
        #2;
    endtask

    task automatic open_lock_to_sec(input logic [AW-1:0] a, input logic [BW-1:0] b);
        q_older_empty = 1'b1;
        drive(1'b1, 2'b00, a, b);
        tick();
        idle_req();
        tick();
        s_gnt = 1'b1;
        tick();
        s_gnt = 1'b0;
        tick();
        s_data_xfer = 1'b1;
        tick();
        s_data_xfer = 1'b0;
        #2;
    endtask

    initial begin
        rst_n = 1'b0; p_req_valid = 1'b0; p_req_locked = 1'b0; p_req_cmd = 2'b00;
        p_addr = '0; p_be = '0; p_frame_n = 1'b1; p_lock_n = 1'b1;
        q_older_empty = 1'b0; s_up_lock_req = 1'b0; s_lock_n_in = 1'b1;
        s_bus_idle = 1'b1; s_gnt = 1'b0; s_data_xfer = 1'b0;
        master_timeout = 1'b0; serr_en = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #2;

        // R1 reset state
        chk("R1 sec_est", lock_sec_est, 1'b0);
        chk("R1 pri_est", lock_pri_est, 1'b0);
        chk("R1 lock_oe", s_lock_oe, 1'b0);
        chk("R1 s_req", s_req, 1'b0);
        chk("R1 serr_n", serr_n, 1'b1);
        chk("R1 accept", p_accept, 1'b0);
        chk("R1 retry", p_retry, 1'b0);

        // R2 unlocked sweep in idle
        for (int c = 0; c < 4; c++) begin
            drive(1'b0, 2'(c), '0, '0);
            chk("R2 accept", p_accept, 1'b1);
            chk("R2 retry", p_retry, 1'b0);
            chk("R2 enq", q_enq, 1'b1);
            chk("R2 enq_locked", q_enq_locked, 1'b0);
            chk("R2 post", q_post, c == 1);
            chk("R2 prefetch", q_prefetch, c == 0);
        end
        idle_req();

        // R3 upstream lock never forwarded
        s_up_lock_req = 1'b1; #2;
        chk("R3 retry", s_up_lock_retry, 1'b1);
        chk("R3 no enq", q_enq, 1'b0);
        s_up_lock_req = 1'b0; #2;
        chk("R3 quiet", s_up_lock_retry, 1'b0);

        // R4 invalid openers are retried
        for (int c = 1; c < 4; c++) begin
            drive(1'b1, 2'(c), LA, LB);
            chk("R4 retry non-read", p_retry, 1'b1);
            chk("R4 no enq", q_enq, 1'b0);
        end
        s_lock_n_in = 1'b0;
        drive(1'b1, 2'b00, LA, LB);
        chk("R4 retry busy target", p_retry, 1'b1);
        chk("R4 no enq busy", q_enq, 1'b0);
        tick();
        s_lock_n_in = 1'b1;
        drive(1'b0, 2'b00, '0, '0);
        chk("R4 still idle", p_accept, 1'b1);
        chk("R4 no lock", s_lock_oe, 1'b0);

        // R4 valid opener
        drive(1'b1, 2'b00, LA, LB);
        chk("R4 accept", p_accept, 1'b1);
        chk("R4 enq_locked", q_enq_locked, 1'b1);
        chk("R4 no prefetch", q_prefetch, 1'b0);
        chk("R4 no post", q_post, 1'b0);
        tick();
        idle_req();

        // R5 everything retried while draining; R6 no request yet
        for (int c = 0; c < 4; c++) begin
            for (int lk = 0; lk < 2; lk++) begin
                drive(lk[0], 2'(c), LA, LB);
                chk("R5 retry drain", p_retry, 1'b1);
                chk("R5 no enq drain", q_enq, 1'b0);
            end
        end
        idle_req();
        tick();
        chk("R6 no req before drain", s_req, 1'b0);
        q_older_empty = 1'b1;
        tick();
        s_lock_n_in = 1'b0; #2;
        chk("R6 no req target locked", s_req, 1'b0);
        s_lock_n_in = 1'b1; s_bus_idle = 1'b0; #2;
        chk("R6 no req bus busy", s_req, 1'b0);
        s_bus_idle = 1'b1; #2;
        chk("R6 req", s_req, 1'b1);
        drive(1'b1, 2'b00, LA, LB);
        chk("R5 retry before data", p_retry, 1'b1);
        chk("R5 no data", p_data_ret, 1'b0);
        idle_req();

        // R7 address phase then lock low
        s_gnt = 1'b1;
        tick();
        s_gnt = 1'b0; #2;
        chk("R7 addr phase", s_addr_phase, 1'b1);
        chk("R7 oe addr", s_lock_oe, 1'b1);
        chk("R7 high addr", s_lock_n_out, 1'b1);
        tick();
        chk("R7 oe hold", s_lock_oe, 1'b1);
        chk("R7 low hold", s_lock_n_out, 1'b0);
        chk("R7 addr over", s_addr_phase, 1'b0);
        tick();
        chk("R8 no sec before xfer", lock_sec_est, 1'b0);
        s_data_xfer = 1'b1;
        tick();
        s_data_xfer = 1'b0; #2;
        chk("R8 sec est", lock_sec_est, 1'b1);
        chk("R8 pri not yet", lock_pri_est, 1'b0);
        chk("R7 still low", s_lock_n_out, 1'b0);

        // R8 exhaustive repeat-match sweep
        for (int a = 0; a < (1 << AW); a++) begin
            for (int b = 0; b < (1 << BW); b++) begin
                for (int lk = 0; lk < 2; lk++) begin
                    drive(lk[0], 2'b00, AW'(a), BW'(b));
                    chk("R8 data_ret", p_data_ret,
                        (lk == 1) && (a == int'(LA)) && (b == int'(LB)));
                    chk("R8 retry", p_retry,
                        !((lk == 1) && (a == int'(LA)) && (b == int'(LB))));
                end
            end
        end
        drive(1'b1, 2'b01, LA, LB);
        chk("R8 write repeat retried", p_retry, 1'b1);
        idle_req();
        tick();
        chk("R8 pri still clear", lock_pri_est, 1'b0);
        p_lock_n = 1'b0; p_frame_n = 1'b0;
        drive(1'b1, 2'b00, LA, LB);
        chk("R8 match", p_data_ret, 1'b1);
        tick();
        idle_req();
        chk("R8 pri est", lock_pri_est, 1'b1);

        // R10 locked-state sweep
        for (int c = 0; c < 4; c++) begin
            for (int lk = 0; lk < 2; lk++) begin
                drive(lk[0], 2'(c), '0, '0);
                chk("R10 accept", p_accept, (lk == 1) && (c < 2));
                chk("R10 retry", p_retry, !((lk == 1) && (c < 2)));
                chk("R10 enq_locked", q_enq_locked, (lk == 1) && (c < 2));
                chk("R10 post", q_post, (lk == 1) && (c == 1));
                chk("R10 prefetch", q_prefetch, 1'b0);
            end
        end
        idle_req();

        // R11 release only on idle primary bus
        p_frame_n = 1'b1; p_lock_n = 1'b0;
        tick();
        chk("R11 held frame high", lock_pri_est, 1'b1);
        p_frame_n = 1'b0; p_lock_n = 1'b1;
        tick();
        chk("R11 held lock high", lock_pri_est, 1'b1);
        p_frame_n = 1'b1; p_lock_n = 1'b1;
        tick();
        chk("R11 pri clear", lock_pri_est, 1'b0);
        chk("R11 sec clear", lock_sec_est, 1'b0);
        chk("R11 oe clear", s_lock_oe, 1'b0);
        drive(1'b0, 2'b00, '0, '0);
        chk("R11 normal accept", p_accept, 1'b1);
        chk("R11 prefetch back", q_prefetch, 1'b1);
        idle_req();

        // R9 timeout with report enabled
        open_lock_to_sec(3'd1, 2'd1);
        chk("R9 reached sec", lock_sec_est, 1'b1);
        serr_en = 1'b1; master_timeout = 1'b1; #2;
        chk("R9 discard", q_discard, 1'b1);
        tick();
        master_timeout = 1'b0; #2;
        chk("R9 sec clear", lock_sec_est, 1'b0);
        chk("R9 oe clear", s_lock_oe, 1'b0);
        chk("R9 serr low", serr_n, 1'b0);
        tick();
        chk("R9 serr one cycle", serr_n, 1'b1);

        // R9 timeout while draining with report disabled
        serr_en = 1'b0; q_older_empty = 1'b0;
        drive(1'b1, 2'b00, LA, LB);
        tick();
        idle_req();
        master_timeout = 1'b1; #2;
        chk("R9 discard drain", q_discard, 1'b1);
        tick();
        master_timeout = 1'b0; #2;
        chk("R9 serr masked", serr_n, 1'b1);
        drive(1'b0, 2'b01, '0, '0);
        chk("R9 idle again", p_accept, 1'b1);
        idle_req();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule